// File: doc/BRIEF.md
# SIMD Pixel Pack and Format Unit

This unit reshapes packed pixel data between wide fixed-point lanes and narrow byte or halfword lanes. Each issue supplies two 64-bit operands, a 64-bit graphics status word and a 3-bit operation code. The unit can narrow signed lanes to clamped bytes or saturated halfwords, with a left scale taken from the status word. It can also widen bytes into 16-bit lanes, or interleave the bytes of two 32-bit words.

All arithmetic is combinational. The result is captured on the rising clock edge when `in_valid` is high, and `out_valid` is raised for exactly the following cycle. When an operation produces only 32 bits, the result sits in bits [31:0] and bits [63:32] read zero. Between issues the registered result holds its value.

Top module: `pxfmt_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. `result` is unchanged after any cycle in which `in_valid` was low.
- R3: Op code 1 (byte pack) splits `opb` into four signed 16-bit lanes. Lane i is shifted left by the scale in `gsr[6:3]`, then shifted arithmetically right by 7, then clamped to 0..255. The outcome goes to result byte i, and `result[63:32]` is zero.
- R4: Byte pack ignores `gsr[7]`. Its scale never exceeds 15.
- R5: Op code 2 (word pack with shift-in) starts from `opa` shifted left by 8, with result bytes 0 and 4 cleared. Each signed 32-bit lane of `opb` is shifted left by the scale in `gsr[7:3]`, arithmetically right by 23, and clamped to 0..255. Lane 0 is ORed into byte 0 and lane 1 into byte 4.
- R6: Op code 3 (fixed pack) treats `opb` as two signed 32-bit lanes. Each lane is shifted left by the scale in `gsr[7:3]`, arithmetically right by 16, and saturated to -32768..32767. Lane 0 goes to `result[15:0]` and lane 1 to `result[31:16]`, and `result[63:32]` is zero.
- R7: Op code 4 (expand) takes the four unsigned bytes of `opb[31:0]`. It shifts each one left by 4 and places byte i in 16-bit result lane i, so bits [3:0] and [15:12] of every lane are zero.
- R8: Op code 5 (merge) places byte k of `opb[31:0]` in result byte 2k and byte k of `opa[31:0]` in result byte 2k+1.
- R9: Op codes 0, 6 and 7 give an all-zero result.
- R10: Scaling is computed wide enough that the largest scale (31) never wraps. A positive lane at maximum scale clamps high and a negative lane clamps low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture the current operation's result |
| op | input | 3 | Operation code |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| gsr | input | 64 | Graphics status word (scale field) |
| out_valid | output | 1 | Result register updated last cycle |
| result | output | 64 | Registered result |

## Verification
The bench builds the unit with its default parameters: a 64-bit word, a wide intermediate of 64 bits and the scale field starting at status bit 3. With these values every scale from 0 to 31 can be reached, including shifts that would overflow a 32-bit intermediate. The byte pack's four-bit scale limit can then be probed by setting status bit 7 alone. Clamp boundaries are hit from both sides in every pack mode, along with the shift-in merge of the first operand and all three unused codes.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

    localparam int WORD_W  = 64;
    localparam int HALF_W  = WORD_W / 2;
    localparam int SCALE_W = 5;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_PACK16  = 3'd1,
        OP_PACK32  = 3'd2,
        OP_PACKFIX = 3'd3,
        OP_EXPAND  = 3'd4,
        OP_MERGE   = 3'd5
    } pxfmt_op_e;

endpackage

// File: rtl/pxfmt_clamp_lane.sv
module pxfmt_clamp_lane #(
    parameter int     SRC_W      = 16,
    parameter int     POST_SHIFT = 7,
    parameter int     OUT_W      = 8,
    parameter int     WIDE_W     = 64,
    parameter int     SCALE_W    = 5,
    parameter longint MIN_VAL    = 0,
    parameter longint MAX_VAL    = 255
) (
    input  logic [SRC_W-1:0]   src,
    input  logic [SCALE_W-1:0] scale,
    output logic [OUT_W-1:0]   dst
);

    localparam int EXT_W = WIDE_W - SRC_W;

    logic signed [WIDE_W-1:0] widened;
    logic signed [WIDE_W-1:0] scaled;
    logic signed [WIDE_W-1:0] fixed_val;
    logic signed [WIDE_W-1:0] lo_lim;
    logic signed [WIDE_W-1:0] hi_lim;

    always_comb begin
        lo_lim    = WIDE_W'(MIN_VAL);
        hi_lim    = WIDE_W'(MAX_VAL);
        widened   = $signed({{EXT_W{src[SRC_W-1]}}, src});
        scaled    = widened <<< scale;
        fixed_val = scaled >>> POST_SHIFT;
        if (fixed_val < lo_lim) begin
            dst = lo_lim[OUT_W-1:0];
        end else if (fixed_val > hi_lim) begin
            dst = hi_lim[OUT_W-1:0];
        end else begin
            dst = fixed_val[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/pxfmt_spread.sv
module pxfmt_spread #(
    parameter int IN_W = 32
) (
    input  logic [IN_W-1:0]   src_a,
    input  logic [IN_W-1:0]   src_b,
    output logic [2*IN_W-1:0] expanded,
    output logic [2*IN_W-1:0] merged
);

    localparam int NBYTES = IN_W / 8;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign expanded[16*k +: 16]  = {4'h0, src_b[8*k +: 8], 4'h0};
        assign merged[16*k +: 8]     = src_b[8*k +: 8];
        assign merged[16*k + 8 +: 8] = src_a[8*k +: 8];
    end

endmodule

// File: rtl/pxfmt_unit.sv
module pxfmt_unit
    import pxfmt_pkg::*;
#(
    parameter int SCALE_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [WORD_W-1:0] gsr,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);

    localparam int N16 = WORD_W / 16;
    localparam int N32 = WORD_W / 32;

    logic [SCALE_W-1:0] scale_narrow;
    logic [SCALE_W-1:0] scale_wide;
    logic [HALF_W-1:0]  pack16_w;
    logic [WORD_W-1:0]  pack32_w;
    logic [WORD_W-1:0]  pack32_base;
    logic [HALF_W-1:0]  packfix_w;
    logic [WORD_W-1:0]  expand_w;
    logic [WORD_W-1:0]  merge_w;
    logic [WORD_W-1:0]  next_result;

    assign scale_narrow = {1'b0, gsr[SCALE_LSB +: SCALE_W-1]};
    assign scale_wide   = gsr[SCALE_LSB +: SCALE_W];

    for (genvar i = 0; i < N16; i++) begin : g_p16
        pxfmt_clamp_lane #(
            .SRC_W(16), .POST_SHIFT(7), .OUT_W(8), .WIDE_W(WORD_W),
            .SCALE_W(SCALE_W), .MIN_VAL(0), .MAX_VAL(255)
        ) u_lane (
            .src(opb[16*i +: 16]), .scale(scale_narrow), .dst(pack16_w[8*i +: 8])
        );
    end

    logic [7:0] p32_byte [N32];
    for (genvar i = 0; i < N32; i++) begin : g_p32
        pxfmt_clamp_lane #(
            .SRC_W(32), .POST_SHIFT(23), .OUT_W(8), .WIDE_W(WORD_W),
            .SCALE_W(SCALE_W), .MIN_VAL(0), .MAX_VAL(255)
        ) u_lane (
            .src(opb[32*i +: 32]), .scale(scale_wide), .dst(p32_byte[i])
        );
        pxfmt_clamp_lane #(
            .SRC_W(32), .POST_SHIFT(16), .OUT_W(16), .WIDE_W(WORD_W),
            .SCALE_W(SCALE_W), .MIN_VAL(-32768), .MAX_VAL(32767)
        ) u_fix (
            .src(opb[32*i +: 32]), .scale(scale_wide), .dst(packfix_w[16*i +: 16])
        );
        assign pack32_w[32*i +: 32] = pack32_base[32*i +: 32] | {24'h0, p32_byte[i]};
    end

    always_comb begin
        pack32_base = opa << 8;
        for (int i = 0; i < N32; i++) begin
            pack32_base[32*i +: 8] = 8'h00;
        end
    end

    pxfmt_spread #(.IN_W(HALF_W)) u_spread (
        .src_a(opa[HALF_W-1:0]),
        .src_b(opb[HALF_W-1:0]),
        .expanded(expand_w),
        .merged(merge_w)
    );

    always_comb begin
        unique case (op)
            OP_PACK16:  next_result = {{HALF_W{1'b0}}, pack16_w};
            OP_PACK32:  next_result = pack32_w;
            OP_PACKFIX: next_result = {{HALF_W{1'b0}}, packfix_w};
            OP_EXPAND:  next_result = expand_w;
            OP_MERGE:   next_result = merge_w;
            default:    next_result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_result;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R3
    pack16_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_PACK16) |=> (result[WORD_W-1:HALF_W] == '0));

    // R6
    packfix_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_PACKFIX) |=> (result[WORD_W-1:HALF_W] == '0));

    // R7
    expand_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_EXPAND) |=> ((result & 64'hF00F_F00F_F00F_F00F) == '0));

    // R9
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd0 || op == 3'd6 || op == 3'd7)) |=> (result == '0));

endmodule

// File: tb/pxfmt_unit_test.sv
module pxfmt_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [63:0] gsr = '0;
    logic        out_valid;
    logic [63:0] result;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pxfmt_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .gsr(gsr), .out_valid(out_valid), .result(result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint clampv(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a,
                                          input logic [63:0] b, input logic [63:0] g);
        logic [63:0] r;
        int sn;
        int sw;
        longint v;
        r = '0;
        sn = int'(g[6:3]);
        sw = int'(g[7:3]);
        case (o)
            3'd1: for (int i = 0; i < 4; i++) begin
                v = longint'($signed(b[16*i +: 16]));
                v = (v <<< sn) >>> 7;
                r[8*i +: 8] = 8'(clampv(v, 0, 255));
            end
            3'd2: begin
                r = a << 8;
                r[7:0] = 8'h00;
                r[39:32] = 8'h00;
                for (int i = 0; i < 2; i++) begin
                    v = longint'($signed(b[32*i +: 32]));
                    v = (v <<< sw) >>> 23;
                    r[32*i +: 8] = r[32*i +: 8] | 8'(clampv(v, 0, 255));
                end
            end
            3'd3: for (int i = 0; i < 2; i++) begin
                v = longint'($signed(b[32*i +: 32]));
                v = (v <<< sw) >>> 16;
                r[16*i +: 16] = 16'(clampv(v, -32768, 32767));
            end
            3'd4: for (int i = 0; i < 4; i++) r[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
            3'd5: for (int i = 0; i < 4; i++) begin
                r[16*i +: 8] = b[8*i +: 8];
                r[16*i + 8 +: 8] = a[8*i +: 8];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic issue(input logic [2:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] g);
        @(negedge clk);
        op = o; opa = a; opb = b; gsr = g; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_op(input string req, input logic [2:0] o, input logic [63:0] a,
                          input logic [63:0] b, input logic [63:0] g);
        issue(o, a, b, g);
        check(req, result, model(o, a, b, g));
    endtask

    task automatic test_reset();
        // R1
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", result, 64'd0);
    endtask

    task automatic test_valid_timing();
        logic [63:0] held;
        issue(3'd5, 64'h1111, 64'h2222, 64'd0);
        check("R2 out_valid high", {63'd0, out_valid}, 64'd1);
        held = result;
        @(negedge clk);
        op = 3'd4; opb = 64'hFFFF_FFFF;
        check("R2 out_valid low", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check("R2 hold", result, held);
    endtask

    task automatic test_pack16();
        run_op("R3 scale0", 3'd1, 64'd0, 64'h7FFF_8000_0100_0080, 64'd0);
        run_op("R3 scale5", 3'd1, 64'd0, 64'h0003_0010_FFF0_0020, 64'(5 << 3));
        check("R3 literal", result, model(3'd1, 0, 64'h0003_0010_FFF0_0020, 64'(5 << 3)));
        // R4: bit 7 alone must leave scale at 0; 0x0100 -> 2
        run_op("R4 bit7 ignored", 3'd1, 64'd0, 64'h0000_0000_0000_0100, 64'h80);
        check("R4 literal", result, 64'h0000_0000_0000_0002);
    endtask

    task automatic test_pack32();
        run_op("R5 shift-in", 3'd2, 64'h1234_5678_9ABC_DEF0, 64'h0040_0000_0080_0000, 64'd0);
        check("R5 literal", result, 64'h3456_7800_BCDE_F001);
        run_op("R5 scale", 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_1000_FFFF_F000, 64'(8 << 3));
        // R10: scale 31, lane 1 clamps to 255, lane -1 clamps to 0
        run_op("R10 pack32 max", 3'd2, 64'd0, 64'hFFFF_FFFF_0000_0001, 64'(31 << 3));
        check("R10 literal", result, 64'h0000_0000_0000_00FF);
    endtask

    task automatic test_packfix();
        run_op("R6 plain", 3'd3, 64'd0, 64'h0001_8000_FFFF_0000, 64'd0);
        check("R6 literal", result, 64'h0000_0000_0001_FFFF);
        run_op("R6 saturate", 3'd3, 64'd0, 64'h8000_0000_7FFF_FFFF, 64'(4 << 3));
        check("R6 sat literal", result, 64'h0000_0000_8000_7FFF);
        run_op("R10 packfix max", 3'd3, 64'd0, 64'hFFFF_FFFF_0000_0001, 64'(31 << 3));
    endtask

    task automatic test_expand_merge();
        run_op("R7 expand", 3'd4, 64'hDEAD, 64'hAAAA_AAAA_80FF_0102, 64'd0);
        check("R7 literal", result, 64'h0800_0FF0_0010_0020);
        run_op("R8 merge", 3'd5, 64'hFFFF_FFFF_A3A2_A1A0, 64'h0000_0000_B3B2_B1B0, 64'd0);
        check("R8 literal", result, 64'hA3B3_A2B2_A1B1_A0B0);
    endtask

    task automatic test_unused();
        for (int k = 0; k < 3; k++) begin
            logic [2:0] code;
            code = (k == 0) ? 3'd0 : 3'(k + 5);
            issue(3'd5, 64'h55, 64'h66, 64'd0);
            issue(code, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF);
            check("R9 unused code", result, 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_valid_timing();
        test_pack16();
        test_pack32();
        test_packfix();
        test_expand_merge();
        test_unused();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                mismatched++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule